// File: doc/BRIEF.md
# Multifunction ALU With Shifter

A 32-bit combinational arithmetic and logic unit. One datapath holds a parallel-prefix adder/subtractor, a bitwise logic unit and a five-stage barrel shifter. A two-bit function-class field picks which of these drives the result. Subtraction reuses the adder by inverting the second operand and forcing a carry-in of one. A set-less-than class uses the same subtraction, corrected for signed overflow, to return a single-bit comparison.

The shifter moves operand `y`. The shift amount is either the constant `shamt_i` or, in variable mode, the low five bits of operand `x`. Logical shifts fill with zeros. The arithmetic right shift copies bit 31 of `y` into the vacated positions. The adder's carry-out is always present on `carry_o`.

Top module: `mf_alu`

## Requirements
- R1: `fclass_i` selects the result: 00 shifter, 01 set-less-than, 10 adder, 11 logic unit.
- R2: With `fclass_i`=10 and `sub_i`=0, `result_o` = (x + y) mod 2^32.
- R3: With `fclass_i`=10 and `sub_i`=1, `result_o` = x + ~y + 1 mod 2^32, which equals x - y.
- R4: `carry_o` is bit 32 of the adder sum in every class. The adder subtracts when `sub_i`=1 or `fclass_i`=01, so for a subtraction `carry_o`=1 means no borrow.
- R5: With `fclass_i`=11, `lop_i` selects the function: 00 AND, 01 OR, 10 XOR, 11 NOR.
- R6: With `fclass_i`=01, `result_o` is 1 when x < y as signed 32-bit values and 0 otherwise, and bits 31..1 are zero. The comparison stays correct when the subtraction overflows.
- R7: `sh_op_i` selects the shift: 00 passes `y` through unchanged whatever the amount, 01 shifts left logically, 10 shifts right logically with zero fill.
- R8: `sh_op_i`=11 shifts right arithmetically and fills every vacated bit with y[31].
- R9: With `sh_var_i`=0 the amount is `shamt_i`. With `sh_var_i`=1 the amount is x[4:0], and x[31:5] has no effect on the result.
- R10: An amount of 0 returns `y` unchanged, and every amount from 1 to 31 shifts by exactly that many places.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| x_i | input | 32 | First operand; its low 5 bits are the variable shift amount |
| y_i | input | 32 | Second operand; the data that is shifted |
| shamt_i | input | 5 | Constant shift amount |
| fclass_i | input | 2 | Function class |
| sub_i | input | 1 | 1 selects subtraction |
| sh_var_i | input | 1 | 1 takes the shift amount from x_i[4:0] |
| sh_op_i | input | 2 | Shift operation |
| lop_i | input | 2 | Logic function |
| result_o | output | 32 | Selected result |
| carry_o | output | 1 | Adder carry-out |

## Verification
The block has no state, so a fault shows at the ports in the same cycle as the input that exposes it. The risk lies in structure that only some patterns reach. A wrong span in the prefix network corrupts the sum only when a carry must cross that span, which is why long carry chains such as all-ones plus one are driven on purpose. A miswired shifter stage shows only for amounts that use that power of two, and a wrong sign fill shows only for negative `y` under an arithmetic shift. Directed corners are therefore combined with a broad random sweep, and every vector is compared against a behavioural model.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [1:0] {
    CLS_SHIFT = 2'b00,
    CLS_SLT   = 2'b01,
    CLS_ARITH = 2'b10,
    CLS_LOGIC = 2'b11
  } fclass_e;

  typedef enum logic [1:0] {
    LOP_AND = 2'b00,
    LOP_OR  = 2'b01,
    LOP_XOR = 2'b10,
    LOP_NOR = 2'b11
  } lop_e;

  typedef enum logic [1:0] {
    SH_NONE = 2'b00,
    SH_SLL  = 2'b01,
    SH_SRL  = 2'b10,
    SH_SRA  = 2'b11
  } shop_e;
endpackage

// File: rtl/alu_prefix_add.sv
module alu_prefix_add #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         co_o
);
  // carry-in becomes position 0 of an extended (W+1)-wide prefix problem
  localparam int N = W + 1;
  localparam int L = $clog2(N);

  logic [W-1:0] hp;
  assign hp = a_i ^ b_i;

  for (genvar l = 0; l <= L; l++) begin : g_lv
    logic [N-1:0] g;
    logic [N-1:0] p;
    if (l == 0) begin : g_init
      assign g = {a_i & b_i, cin_i};
      assign p = {hp, 1'b0};
    end else begin : g_comb
      for (genvar i = 0; i < N; i++) begin : g_bit
        localparam int S = l - 1;
        if (((i >> S) & 1) == 1) begin : g_op
          localparam int J = ((i >> S) << S) - 1;
          assign g[i] = g_lv[l-1].g[i] | (g_lv[l-1].p[i] & g_lv[l-1].g[J]);
          assign p[i] = g_lv[l-1].p[i] & g_lv[l-1].p[J];
        end else begin : g_pass
          assign g[i] = g_lv[l-1].g[i];
          assign p[i] = g_lv[l-1].p[i];
        end
      end
    end
  end

  assign sum_o = hp ^ g_lv[L].g[W-1:0];
  assign co_o  = g_lv[L].g[W];

  always_comb begin
    assert_prefix_sum_R2: assert ({co_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i}))
      else $error("prefix adder sum mismatch");
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [1:0]   op_i,
  output logic [W-1:0] y_o
);
  import alu_pkg::*;

  always_comb begin
    unique case (lop_e'(op_i))
      LOP_AND: y_o = a_i & b_i;
      LOP_OR:  y_o = a_i | b_i;
      LOP_XOR: y_o = a_i ^ b_i;
      default: y_o = ~(a_i | b_i);
    endcase
  end

  always_comb begin
    if (op_i == LOP_NOR)
      assert_nor_disjoint_R5: assert ((y_o & (a_i | b_i)) == '0 && (y_o | a_i | b_i) == '1)
        else $error("NOR result overlaps operands");
  end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int W  = 32,
  parameter int LG = $clog2(W)
) (
  input  logic [W-1:0]  d_i,
  input  logic [LG-1:0] amt_i,
  input  logic [1:0]    op_i,
  output logic [W-1:0]  d_o
);
  import alu_pkg::*;

  logic [LG-1:0] ea;
  logic          left;
  logic          fill;

  assign ea   = (op_i == SH_NONE) ? '0 : amt_i;
  assign left = (op_i == SH_SLL);
  assign fill = (op_i == SH_SRA) & d_i[W-1];

  for (genvar s = 0; s < LG; s++) begin : g_st
    localparam int D = 1 << s;
    logic [W-1:0] prev;
    logic [W-1:0] v;
    if (s == 0) begin : g_first
      assign prev = d_i;
    end else begin : g_next
      assign prev = g_st[s-1].v;
    end
    always_comb begin
      if (!ea[s])   v = prev;
      else if (left) v = {prev[W-1-D:0], {D{1'b0}}};
      else          v = {{D{fill}}, prev[W-1:D]};
    end
  end

  assign d_o = g_st[LG-1].v;

  always_comb begin
    if (ea == '0)
      assert_zero_amt_R10: assert (d_o == d_i) else $error("zero shift altered data");
    if (op_i == SH_SRA && ea != '0)
      assert_sra_fill_R8: assert (d_o[W-1] == d_i[W-1]) else $error("sign fill lost");
    if (op_i == SH_SRL && ea != '0)
      assert_srl_zero_R7: assert (d_o[W-1] == 1'b0) else $error("logical right left msb set");
  end
endmodule

// File: rtl/mf_alu.sv
module mf_alu #(
  parameter int W = 32,
  localparam int LG = $clog2(W)
) (
  input  logic [W-1:0]  x_i,
  input  logic [W-1:0]  y_i,
  input  logic [LG-1:0] shamt_i,
  input  logic [1:0]    fclass_i,
  input  logic          sub_i,
  input  logic          sh_var_i,
  input  logic [1:0]    sh_op_i,
  input  logic [1:0]    lop_i,
  output logic [W-1:0]  result_o,
  output logic          carry_o
);
  import alu_pkg::*;

  logic          do_sub;
  logic [W-1:0]  y_eff;
  logic [W-1:0]  sum;
  logic          co;
  logic [W-1:0]  lres;
  logic [W-1:0]  sres;
  logic [LG-1:0] amt;
  logic          ovf;
  logic          less;

  assign do_sub = sub_i | (fclass_i == CLS_SLT);
  assign y_eff  = do_sub ? ~y_i : y_i;

  alu_prefix_add #(.W(W)) u_add (
    .a_i(x_i), .b_i(y_eff), .cin_i(do_sub), .sum_o(sum), .co_o(co)
  );

  alu_logic #(.W(W)) u_log (
    .a_i(x_i), .b_i(y_i), .op_i(lop_i), .y_o(lres)
  );

  assign amt = sh_var_i ? x_i[LG-1:0] : shamt_i;

  alu_shifter #(.W(W)) u_sh (
    .d_i(y_i), .amt_i(amt), .op_i(sh_op_i), .d_o(sres)
  );

  // signed overflow: equal operand signs, result sign differs
  assign ovf  = (x_i[W-1] == y_eff[W-1]) & (sum[W-1] != x_i[W-1]);
  assign less = sum[W-1] ^ ovf;

  always_comb begin
    unique case (fclass_e'(fclass_i))
      CLS_SHIFT: result_o = sres;
      CLS_SLT:   result_o = {{(W-1){1'b0}}, less};
      CLS_ARITH: result_o = sum;
      default:   result_o = lres;
    endcase
  end

  assign carry_o = co;

  always_comb begin
    if (fclass_i == CLS_SLT)
      assert_slt_signed_R6: assert (result_o == (($signed(x_i) < $signed(y_i)) ? 1 : 0))
        else $error("set-less-than wrong");
    if (fclass_i == CLS_ARITH && sub_i)
      assert_sub_diff_R3: assert (result_o == x_i - y_i) else $error("difference wrong");
  end
endmodule

// File: tb/sim_mf_alu.sv
module sim_mf_alu;
  logic        clk = 1'b0;
  logic [31:0] x, y, res;
  logic [4:0]  shamt;
  logic [1:0]  fcls, shop, lop;
  logic        sub, shvar, co;
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  mf_alu u0 (
    .x_i(x), .y_i(y), .shamt_i(shamt), .fclass_i(fcls), .sub_i(sub),
    .sh_var_i(shvar), .sh_op_i(shop), .lop_i(lop), .result_o(res), .carry_o(co)
  );

  function automatic logic [32:0] model(input logic [31:0] a, b, input logic [4:0] sa,
                                        input logic [1:0] c, input logic s, sv,
                                        input logic [1:0] so, lo);
    longint unsigned ua = a, ub = b, tot;
    logic [31:0] r;
    logic        cy;
    int          n;
    if (s || c == 2'b01) tot = ua + (64'hFFFF_FFFF - ub) + 1;
    else                 tot = ua + ub;
    cy = tot[32];
    n = sv ? int'(a % 32) : int'(sa);
    case (c)
      2'b00: case (so)
               2'b00: r = b;
               2'b01: r = b << n;
               2'b10: r = b >> n;
               default: r = 32'($signed(b) >>> n);
             endcase
      2'b01: r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      2'b10: r = tot[31:0];
      default: case (lo)
               2'b00: r = a & b;
               2'b01: r = a | b;
               2'b10: r = a ^ b;
               default: r = ~(a | b);
             endcase
    endcase
    return {cy, r};
  endfunction

  task automatic run(input logic [31:0] a, b, input logic [4:0] sa, input logic [1:0] c,
                     input logic s, sv, input logic [1:0] so, lo, input string tag);
    logic [32:0] exp;
    @(negedge clk);
    x = a; y = b; shamt = sa; fcls = c; sub = s; shvar = sv; shop = so; lop = lo;
    exp = model(a, b, sa, c, s, sv, so, lo);
    @(posedge clk); #1;
    n_cmp++;
    if ({co, res} !== exp) begin
      n_bad++;
      $display("FAIL %s: got carry=%0b result=%h, expected carry=%0b result=%h",
               tag, co, res, exp[32], exp[31:0]);
    end
  endtask

  initial begin
    x = '0; y = '0; shamt = '0; fcls = '0; sub = 0; shvar = 0; shop = '0; lop = '0;
    run(0, 0, 0, 2'b00, 0, 0, 2'b00, 2'b00, "R1 idle zero");
    run(32'h1234_5678, 32'h0000_1111, 0, 2'b10, 0, 0, 0, 0, "R2 add");
    run(32'hFFFF_FFFF, 32'h1, 0, 2'b10, 0, 0, 0, 0, "R2 R4 full carry chain");
    run(32'h8000_0000, 32'h8000_0000, 0, 2'b10, 0, 0, 0, 0, "R4 carry top");
    run(32'h10, 32'h10, 0, 2'b10, 1, 0, 0, 0, "R3 sub equal no borrow");
    run(32'h5, 32'h7, 0, 2'b10, 1, 0, 0, 0, "R3 sub borrow");
    run(32'h0, 32'h1, 0, 2'b11, 1, 0, 0, 2'b00, "R4 carry in logic class");
    run(32'hF0F0_1234, 32'hFF00_5678, 0, 2'b11, 0, 0, 0, 2'b00, "R5 AND");
    run(32'hF0F0_1234, 32'hFF00_5678, 0, 2'b11, 0, 0, 0, 2'b01, "R5 OR");
    run(32'hF0F0_1234, 32'hFF00_5678, 0, 2'b11, 0, 0, 0, 2'b10, "R5 XOR");
    run(32'hF0F0_1234, 32'hFF00_5678, 0, 2'b11, 0, 0, 0, 2'b11, "R5 NOR");
    run(32'h8000_0000, 32'h1, 0, 2'b01, 0, 0, 0, 0, "R6 slt overflow true");
    run(32'h7FFF_FFFF, 32'hFFFF_FFFF, 0, 2'b01, 0, 0, 0, 0, "R6 slt overflow false");
    run(32'hFFFF_FFFE, 32'hFFFF_FFFF, 0, 2'b01, 0, 0, 0, 0, "R6 slt negatives");
    run(32'h3, 32'h3, 0, 2'b01, 0, 0, 0, 0, "R6 slt equal");
    run(0, 32'hDEAD_BEEF, 5'd9, 2'b00, 0, 0, 2'b00, 0, "R7 no shift ignores amount");
    run(0, 32'h8000_0001, 5'd4, 2'b00, 0, 0, 2'b01, 0, "R7 sll");
    run(0, 32'h8000_0001, 5'd4, 2'b00, 0, 0, 2'b10, 0, "R7 srl");
    run(0, 32'h8000_0010, 5'd31, 2'b00, 0, 0, 2'b11, 0, "R8 sra 31 negative");
    run(0, 32'h7000_0010, 5'd3, 2'b00, 0, 0, 2'b11, 0, "R8 sra positive");
    run(32'hFFFF_FFE3, 32'hC000_0000, 5'd17, 2'b00, 0, 1, 2'b11, 0, "R9 variable uses low bits");
    run(32'h0000_0003, 32'hC000_0000, 5'd17, 2'b00, 0, 1, 2'b11, 0, "R9 variable low bits only");
    run(32'h1F, 32'h1234_5678, 5'd2, 2'b00, 0, 0, 2'b01, 0, "R9 constant ignores x");
    run(0, 32'hA5A5_5A5A, 5'd0, 2'b00, 0, 0, 2'b11, 0, "R10 amount zero");
    for (int k = 0; k < 32; k++)
      run(0, 32'h8765_4321, 5'(k), 2'b00, 0, 0, 2'b01 + 2'(k % 3), 0, "R10 amount sweep");
    for (int k = 0; k < 3000; k++)
      run($urandom, $urandom, 5'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
          2'($urandom), 2'($urandom), "R1 random");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule